// File: doc/BRIEF.md
# External Bus Strobe Sequencer

The block times the control strobes of a multiplexed external memory bus. It runs from the oscillator clock and divides it into machine cycles of twelve ticks, organised as six states of two phases each. Every strobe edge is decoded from the current tick and from a small context word. That word is captured once per machine cycle, on its last tick, and it governs the whole of the next cycle.

A machine cycle is one of three kinds. In a fetch cycle (external execution) the address-latch strobe fires twice and the program-store read strobe fires twice. In an internal cycle only the address-latch strobe may fire. In a data cycle the address latch fires once, the program-store strobe stays idle, and a read or write data strobe fires. An address-latch disable input removes the idle latch pulses. It is overridden by external execution and by instructions that move data or look up code. The block also tells the pad logic what the low address/data port and the high address port should carry in each tick.

Top module: `ext_bus_seq`

## Requirements
- R1: While rst_ni is low, and through the whole first machine cycle after its release, ale_o=0, psen_no=1, rd_no=1, wr_no=1, lo_sel_o=0 and hi_sel_o=0. The counter starts at state 0, phase 0.
- R2: The phase toggles on every clock. The state steps on every second clock and wraps from 5 to 0. The tick index within the machine cycle is state*2+phase (0..11).
- R3: In a non-data cycle with the latch enabled, ale_o is high at ticks 0,1 and 6,7: two pulses, each two clocks wide.
- R4: In a fetch cycle (external execution, no data access), psen_no is low at ticks 3,4,5 and 9,10,11. It is never low outside external execution.
- R5: In a data cycle, ale_o is high only at ticks 0,1, so the second pulse is skipped. psen_no stays high for the whole cycle, so both program-store pulses are skipped. This holds whatever the latch-disable and execution-mode inputs are.
- R6: In a data cycle, the data strobe is low at ticks 3..8: rd_no for a read (acc_wr_i=0), wr_no for a write (acc_wr_i=1). The other data strobe stays high, and rd_no and wr_no are never low together.
- R7: With ale_off_i=1, an internal cycle that is not a data cycle has no address-latch pulse, unless mov_cls_i=1. ale_off_i has no effect when ext_exec_i=1.
- R8: hi_sel_o is 1 (code address) in fetch cycles. In data cycles it is 2 (data address high byte) for a 16-bit access (acc_wide_i=1) and 0 (port latch) for an 8-bit access. It is 0 in internal non-data cycles.
- R9: In fetch and data cycles, lo_sel_o is 1 (address) while ale_o is high. At the other ticks it is 2 (write data) in write cycles and 3 (high impedance) in read and fetch cycles. In internal non-data cycles it is 0 (port latch).
- R10: The control inputs are sampled only on tick 11. Changes to them at other ticks have no effect on the current cycle or the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_exec_i | input | 1 | Code is fetched from external program memory |
| acc_req_i | input | 1 | The next machine cycle is an external data access |
| acc_wr_i | input | 1 | Data access direction: 1 write, 0 read |
| acc_wide_i | input | 1 | Data access uses a 16-bit address |
| ale_off_i | input | 1 | Address-latch disable control bit |
| mov_cls_i | input | 1 | Current instruction is a data-move or code-lookup |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_no | output | 1 | Program-store read strobe, active low |
| rd_no | output | 1 | Data read strobe, active low |
| wr_no | output | 1 | Data write strobe, active low |
| lo_sel_o | output | 2 | Low port source: 0 latch, 1 address, 2 write data, 3 high impedance |
| hi_sel_o | output | 2 | High port source: 0 latch, 1 code address, 2 data address |
| state_o | output | 3 | Machine-cycle state 0..5 |
| phase_o | output | 1 | Phase within the state |

## Verification
The hardest case to reach from the ports is a control change in the middle of a machine cycle. Such a change must neither disturb the cycle in flight nor leak into the next one. The stimulus reaches it by setting the final controls at tick 0, driving their complement at ticks 5 to 7, and restoring them before tick 11. Back-to-back data cycles, and a data cycle with the latch disabled, are also driven so that the skip rules are seen apart from the disable rules.

// File: rtl/bus_seq_pkg.sv
`timescale 1ns/1ps
package bus_seq_pkg;
  typedef enum logic [1:0] {
    LO_LATCH = 2'd0,
    LO_ADDR  = 2'd1,
    LO_DATA  = 2'd2,
    LO_HIZ   = 2'd3
  } lo_sel_e;

  typedef enum logic [1:0] {
    HI_LATCH = 2'd0,
    HI_CODE  = 2'd1,
    HI_DADDR = 2'd2,
    HI_RSV   = 2'd3
  } hi_sel_e;

  typedef struct packed {
    logic vld;
    logic ext;
    logic data;
    logic wr;
    logic wide;
    logic ale_on;
  } cyc_ctx_t;
endpackage

// File: rtl/seq_timer.sv
`timescale 1ns/1ps
module seq_timer #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SW = $clog2(STATES),
  localparam int PW = $clog2(PHASES),
  localparam int TW = $clog2(STATES * PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o,
  output logic [TW-1:0] tick_o,
  output logic          last_o
);
  localparam logic [SW-1:0] ST_LAST = SW'(STATES - 1);
  localparam logic [PW-1:0] PH_LAST = PW'(PHASES - 1);

  logic [SW-1:0] state_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
      phase_q <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      state_q <= (state_q == ST_LAST) ? '0 : state_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign tick_o  = TW'(state_q) * TW'(PHASES) + TW'(phase_q);
  assign last_o  = (state_q == ST_LAST) && (phase_q == PH_LAST);
endmodule

// File: rtl/seq_ctx.sv
`timescale 1ns/1ps
module seq_ctx
  import bus_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     last_i,
  input  logic     ext_i,
  input  logic     req_i,
  input  logic     wr_i,
  input  logic     wide_i,
  input  logic     ale_off_i,
  input  logic     cls_i,
  output cyc_ctx_t ctx_o
);
  // captured once per machine cycle, applies to the whole next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_o <= '0;
    end else if (last_i) begin
      ctx_o.vld    <= 1'b1;
      ctx_o.ext    <= ext_i;
      ctx_o.data   <= req_i;
      ctx_o.wr     <= req_i & wr_i;
      ctx_o.wide   <= req_i & wide_i;
      ctx_o.ale_on <= ~ale_off_i | ext_i | cls_i;
    end
  end
endmodule

// File: rtl/strobe_dec.sv
`timescale 1ns/1ps
module strobe_dec
  import bus_seq_pkg::*;
#(
  parameter int TICKS  = 12,
  parameter int ALE_W  = 2,
  parameter int PS_GAP = 1,
  parameter int PS_W   = 3,
  localparam int TW = $clog2(TICKS)
) (
  input  logic [TW-1:0] tick_i,
  input  cyc_ctx_t      ctx_i,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output lo_sel_e       lo_sel_o,
  output hi_sel_e       hi_sel_o
);
  localparam int HALF = TICKS / 2;
  localparam logic [TW-1:0] HALF_T  = TW'(HALF);
  localparam logic [TW-1:0] ALE_T   = TW'(ALE_W);
  localparam logic [TW-1:0] PS_LO_T = TW'(ALE_W + PS_GAP);
  localparam logic [TW-1:0] PS_HI_T = TW'(ALE_W + PS_GAP + PS_W);
  localparam logic [TW-1:0] DS_HI_T = TW'(ALE_W + PS_GAP + HALF);

  logic          first_half;
  logic [TW-1:0] pos;
  logic          ale_slot, ps_slot, ds_slot;

  assign first_half = tick_i < HALF_T;
  assign pos        = first_half ? tick_i : tick_i - HALF_T;
  assign ale_slot   = pos < ALE_T;
  assign ps_slot    = (pos >= PS_LO_T) && (pos < PS_HI_T);
  // data strobe spans one half cycle, starting where the first read slot would
  assign ds_slot    = (tick_i >= PS_LO_T) && (tick_i < DS_HI_T);

  always_comb begin
    ale_o    = 1'b0;
    psen_no  = 1'b1;
    rd_no    = 1'b1;
    wr_no    = 1'b1;
    lo_sel_o = LO_LATCH;
    hi_sel_o = HI_LATCH;
    if (ctx_i.vld) begin
      if (ctx_i.data) begin
        ale_o    = ale_slot && first_half;
        rd_no    = !(ds_slot && !ctx_i.wr);
        wr_no    = !(ds_slot && ctx_i.wr);
        hi_sel_o = ctx_i.wide ? HI_DADDR : HI_LATCH;
        if (ale_slot && first_half) lo_sel_o = LO_ADDR;
        else lo_sel_o = ctx_i.wr ? LO_DATA : LO_HIZ;
      end else begin
        ale_o = ale_slot && ctx_i.ale_on;
        if (ctx_i.ext) begin
          psen_no  = !ps_slot;
          hi_sel_o = HI_CODE;
          lo_sel_o = ale_slot ? LO_ADDR : LO_HIZ;
        end
      end
    end
  end
endmodule

// File: rtl/ext_bus_seq.sv
`timescale 1ns/1ps
module ext_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  parameter int ALE_W  = 2,
  parameter int PS_GAP = 1,
  parameter int PS_W   = 3,
  localparam int SW = $clog2(STATES),
  localparam int PW = $clog2(PHASES),
  localparam int TICKS = STATES * PHASES,
  localparam int TW = $clog2(TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ext_exec_i,
  input  logic          acc_req_i,
  input  logic          acc_wr_i,
  input  logic          acc_wide_i,
  input  logic          ale_off_i,
  input  logic          mov_cls_i,
  output logic          ale_o,
  output logic          psen_no,
  output logic          rd_no,
  output logic          wr_no,
  output logic [1:0]    lo_sel_o,
  output logic [1:0]    hi_sel_o,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o
);
  logic [TW-1:0] tick;
  logic          last;
  cyc_ctx_t      ctx;
  lo_sel_e       lo_sel;
  hi_sel_e       hi_sel;

  seq_timer #(.STATES(STATES), .PHASES(PHASES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (state_o),
    .phase_o (phase_o),
    .tick_o  (tick),
    .last_o  (last)
  );

  seq_ctx u_ctx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .last_i    (last),
    .ext_i     (ext_exec_i),
    .req_i     (acc_req_i),
    .wr_i      (acc_wr_i),
    .wide_i    (acc_wide_i),
    .ale_off_i (ale_off_i),
    .cls_i     (mov_cls_i),
    .ctx_o     (ctx)
  );

  strobe_dec #(
    .TICKS(TICKS), .ALE_W(ALE_W), .PS_GAP(PS_GAP), .PS_W(PS_W)
  ) u_dec (
    .tick_i   (tick),
    .ctx_i    (ctx),
    .ale_o    (ale_o),
    .psen_no  (psen_no),
    .rd_no    (rd_no),
    .wr_no    (wr_no),
    .lo_sel_o (lo_sel),
    .hi_sel_o (hi_sel)
  );

  assign lo_sel_o = lo_sel;
  assign hi_sel_o = hi_sel;
endmodule

// File: rtl/ext_bus_seq_chk.sv
`timescale 1ns/1ps
module ext_bus_seq_chk #(
  parameter int STATES = 6,
  parameter int PHASES = 2,
  localparam int SW = $clog2(STATES),
  localparam int PW = $clog2(PHASES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ale_o,
  input logic          psen_no,
  input logic          rd_no,
  input logic          wr_no,
  input logic [1:0]    lo_sel_o,
  input logic [SW-1:0] state_o,
  input logic [PW-1:0] phase_o
);
  p_phase_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == '0) |=> (phase_o != '0));

  p_state_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == PW'(PHASES - 1) && state_o == SW'(STATES - 1)) |=> (state_o == '0));

  p_ale_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && !$past(ale_o)) |=> ale_o);

  p_ale_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && $past(ale_o)) |=> !ale_o);

  p_psen_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_no |-> !ale_o);

  p_skip_fetch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> (psen_no && !ale_o));

  p_rw_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  p_wr_drives_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_no |-> (lo_sel_o == 2'd2));

  p_rd_floats_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (lo_sel_o == 2'd3));
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.STATES(STATES), .PHASES(PHASES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ale_o    (ale_o),
  .psen_no  (psen_no),
  .rd_no    (rd_no),
  .wr_no    (wr_no),
  .lo_sel_o (lo_sel_o),
  .state_o  (state_o),
  .phase_o  (phase_o)
);

// File: tb/sim_ext_bus_seq.sv
`timescale 1ns/1ps
module sim_ext_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_exec = 1'b0, acc_req = 1'b0, acc_wr = 1'b0, acc_wide = 1'b0;
  logic ale_off = 1'b0, mov_cls = 1'b0;
  logic ale, psen_n, rd_n, wr_n, phase;
  logic [1:0] lo_sel, hi_sel;
  logic [2:0] state;

  always #2 clk = ~clk;

  ext_bus_seq u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ext_exec_i(ext_exec), .acc_req_i(acc_req), .acc_wr_i(acc_wr),
    .acc_wide_i(acc_wide), .ale_off_i(ale_off), .mov_cls_i(mov_cls),
    .ale_o(ale), .psen_no(psen_n), .rd_no(rd_n), .wr_no(wr_n),
    .lo_sel_o(lo_sel), .hi_sel_o(hi_sel), .state_o(state), .phase_o(phase)
  );

  typedef struct packed {logic ext, req, wr, wide, off, cls;} ctrl_t;
  typedef struct packed {
    logic ale, psen_n, rd_n, wr_n;
    logic [1:0] lo, hi;
    logic [2:0] st;
    logic ph;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;
  event go;

  function automatic ctrl_t mk(bit e, bit r, bit w, bit wd, bit o, bit c);
    ctrl_t x;
    x.ext = e; x.req = r; x.wr = w; x.wide = wd; x.off = o; x.cls = c;
    return x;
  endfunction

  // expected outputs at tick t of a cycle run with controls c
  function automatic exp_t model(int t, ctrl_t c, bit vld);
    exp_t m;
    bit ale_tick;
    m = '0;
    m.psen_n = 1'b1; m.rd_n = 1'b1; m.wr_n = 1'b1;
    m.st = 3'(t / 2);
    m.ph = 1'(t % 2);
    if (!vld) return m;
    ale_tick = (t == 0) || (t == 1) || (t == 6) || (t == 7);
    if (c.req) begin
      m.ale  = (t < 2);
      m.rd_n = !(t >= 3 && t <= 8 && !c.wr);
      m.wr_n = !(t >= 3 && t <= 8 && c.wr);
      m.hi   = c.wide ? 2'd2 : 2'd0;
      m.lo   = (t < 2) ? 2'd1 : (c.wr ? 2'd2 : 2'd3);
    end else begin
      m.ale = ale_tick && (!c.off || c.ext || c.cls);
      if (c.ext) begin
        m.psen_n = !((t >= 3 && t <= 5) || t >= 9);
        m.hi     = 2'd1;
        m.lo     = ale_tick ? 2'd1 : 2'd3;
      end
    end
    return m;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic apply(input ctrl_t c);
    ext_exec = c.ext; acc_req = c.req; acc_wr = c.wr;
    acc_wide = c.wide; ale_off = c.off; mov_cls = c.cls;
  endtask

  task automatic push_cycle(input ctrl_t c, input bit vld, input string tag);
    for (int t = 0; t < 12; t++) begin
      exp_q.push_back(model(t, c, vld));
      tag_q.push_back(tag);
    end
  endtask

  // called at the negedge of tick 0: sets controls for the next cycle
  task automatic drive_cycle(input ctrl_t c, input string tag, input bit noise);
    apply(c);
    push_cycle(c, 1'b1, tag);
    if (noise) begin
      repeat (5) @(negedge clk);
      apply(~c);
      repeat (3) @(negedge clk);
      apply(c);
      repeat (4) @(negedge clk);
    end else begin
      repeat (12) @(negedge clk);
    end
  endtask

  // monitor: pops one expected item per tick
  initial begin
    exp_t e;
    string tg;
    @go;
    forever begin
      #1;
      if (exp_q.size() > 0) begin
        e  = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(tg, "R2 state", int'(state), int'(e.st));
        chk(tg, "R2 phase", int'(phase), int'(e.ph));
        chk(tg, "R3/R5/R7 ale", int'(ale), int'(e.ale));
        chk(tg, "R4/R5 psen_n", int'(psen_n), int'(e.psen_n));
        chk(tg, "R6 rd_n", int'(rd_n), int'(e.rd_n));
        chk(tg, "R6 wr_n", int'(wr_n), int'(e.wr_n));
        chk(tg, "R8 hi_sel", int'(hi_sel), int'(e.hi));
        chk(tg, "R9 lo_sel", int'(lo_sel), int'(e.lo));
      end
      @(negedge clk);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs during reset
    chk("R1", "reset ale", int'(ale), 0);
    chk("R1", "reset psen_n", int'(psen_n), 1);
    chk("R1", "reset rd_n", int'(rd_n), 1);
    chk("R1", "reset wr_n", int'(wr_n), 1);
    chk("R1", "reset lo_sel", int'(lo_sel), 0);
    chk("R1", "reset hi_sel", int'(hi_sel), 0);
    chk("R1", "reset state", int'(state), 0);
    @(negedge clk);
    push_cycle('0, 1'b0, "R1 first cycle quiet");
    rst_n = 1'b1;
    ->go;
    drive_cycle(mk(0,0,0,0,0,0), "R3 internal", 1'b0);
    drive_cycle(mk(1,0,0,0,0,0), "R4 fetch", 1'b0);
    drive_cycle(mk(1,1,0,0,0,0), "R5 read narrow ext", 1'b0);
    drive_cycle(mk(1,1,1,1,0,0), "R6 write wide ext", 1'b0);
    drive_cycle(mk(0,0,0,0,1,0), "R7 off no class", 1'b0);
    drive_cycle(mk(0,0,0,0,1,1), "R7 off with class", 1'b0);
    drive_cycle(mk(1,0,0,0,1,0), "R7 off ext", 1'b0);
    drive_cycle(mk(0,1,0,1,1,0), "R5 read wide off", 1'b0);
    drive_cycle(mk(0,1,1,0,0,1), "R8 write narrow", 1'b0);
    drive_cycle(mk(1,0,0,0,0,0), "R10 mid-cycle change", 1'b1);
    drive_cycle(mk(0,0,0,0,1,0), "R10 mid-cycle change", 1'b1);
    drive_cycle(mk(1,1,0,1,0,0), "R6 back-to-back read 1", 1'b0);
    drive_cycle(mk(1,1,0,1,0,0), "R6 back-to-back read 2", 1'b0);
    drive_cycle(mk(1,1,1,0,1,0), "R9 write after read", 1'b0);
    drive_cycle(mk(1,0,0,0,1,1), "R4 fetch after data", 1'b0);
    repeat (13) @(negedge clk);
    #1;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule